// File: doc/BRIEF.md
# Receive Sampling-Delay Tuning Sweep Engine

This block searches for the best receive sampling delay of a high-speed memory-card link without software involvement. After a start pulse it walks a tap value upward from zero across a fixed number of positions. For each position it loads the value into the delay logic and waits for that logic to accept it. It then lets the delay line settle and asks an external checker to run one tuning-block transfer. The checker answers pass or fail.

While the sweep runs, the engine tracks the longest unbroken run of passing taps. At the end it loads the tap at the centre of that run and reports it together with a done pulse. If no tap passed, it raises an error flag instead. As an errata workaround, every load, including the final one, is made of two update requests in a row. The delay logic must clear each request. An update that is never taken is limited by a timeout and counts as a failing tap.

Every handshake here is a plain control pin. There is no data stream, so no valid/ready back-pressure applies. The checker and the delay logic answer whenever they are ready, and the engine waits for them. Only the update wait is bounded.

Top module: `tune_sweep_engine`

## Requirements
- R1: After an accepted start, taps 0 to NUM_TAPS-1 (default 40) are visited in ascending order. Exactly one check (`chk_start` pulse) is issued for each tap whose update succeeded.
- R2: Each tap is loaded by two update requests. For each, `upd_req` is raised with `tap_field` holding the tap, and it stays high until `upd_taken` is sampled. It then drops for at least one cycle before the second request.
- R3: If `upd_taken` is not sampled within UPD_TIMEOUT clock edges of a request being raised, the request is withdrawn and the tap fails: no check is issued for it and the current run resets. A `upd_taken` in the last edge of the window is accepted.
- R4: A check is issued no sooner than SETTLE_CYC cycles after the last update of the tap was accepted.
- R5: The longest run of consecutive passing taps is kept. A later run replaces it only if strictly longer, so the earliest of equal runs wins.
- R6: The chosen tap is the last tap of the best run minus half the run length, rounded down.
- R7: If no tap passed, the sweep ends with `done` and `err`=1, `tap_sel`=0, and no final update is issued.
- R8: Otherwise the chosen tap is loaded with the same two-request update. After `done`, `tap_field` equals `tap_sel`, and `err`=1 only if that final update timed out.
- R9: A start pulse while `busy` is high has no effect on the running sweep or its result.
- R10: `done` is a one-cycle pulse that coincides with `busy` falling. `tap_sel` and `err` hold their values until the next accepted start.
- R11: After reset, `busy`, `done`, `err`, `upd_req`, `chk_start` and `tap_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a sweep when idle |
| busy | output | 1 | High while a sweep is running |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| err | output | 1 | No passing tap, or final update timed out |
| tap_sel | output | TAP_W | Chosen tap |
| tap_field | output | TAP_W | Tap value presented to the delay logic |
| upd_req | output | 1 | Update request, held until taken |
| upd_taken | input | 1 | Delay logic has taken the value (clears the request) |
| chk_start | output | 1 | Pulse that starts one tuning-block check |
| chk_done | input | 1 | Check finished |
| chk_pass | input | 1 | Check result, valid with chk_done |

## Verification
The two events that can meet in one cycle are an update being taken and the update timeout expiring. The bench delays every `upd_taken` by exactly UPD_TIMEOUT-1 negedges, so it lands on the final edge of the window. That sweep must behave as an all-pass sweep. With one more cycle of delay, every tap must fail and the sweep must end in error with no checks issued. A second overlap is a stray start pulse in the middle of each sweep. It is judged by the check count and the selected tap staying as the table predicts.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_APPLY,
    SW_SETTLE,
    SW_WAIT,
    SW_NEXT,
    SW_PICK,
    SW_FINAL
  } sweep_st_e;

  typedef enum logic [1:0] {
    AP_IDLE,
    AP_REQ,
    AP_GAP
  } apply_st_e;

endpackage

// File: rtl/tune_apply.sv
module tune_apply
  import tune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int UPD_TIMEOUT = 16,
  parameter int UPD_REPEAT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [TAP_W-1:0] tap_in,
  output logic [TAP_W-1:0] tap_field,
  output logic             upd_req,
  input  logic             upd_taken,
  output logic             fin,
  output logic             ok
);

  localparam int TW = $clog2(UPD_TIMEOUT + 1);
  localparam int RW = $clog2(UPD_REPEAT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(UPD_TIMEOUT - 1);
  localparam logic [RW-1:0] R_LAST = RW'(UPD_REPEAT - 1);

  apply_st_e       st;
  logic [TW-1:0]   tcnt;
  logic [RW-1:0]   rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= AP_IDLE;
      tap_field <= '0;
      upd_req   <= 1'b0;
      tcnt      <= '0;
      rep       <= '0;
      fin       <= 1'b0;
      ok        <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        AP_IDLE: begin
          if (go) begin
            tap_field <= tap_in;
            upd_req   <= 1'b1;
            tcnt      <= '0;
            rep       <= '0;
            st        <= AP_REQ;
          end
        end
        AP_REQ: begin
          if (upd_taken) begin
            upd_req <= 1'b0;
            if (rep == R_LAST) begin
              fin <= 1'b1;
              ok  <= 1'b1;
              st  <= AP_IDLE;
            end else begin
              rep <= rep + 1'b1;
              st  <= AP_GAP;
            end
          end else if (tcnt == T_LAST) begin
            upd_req <= 1'b0;
            fin     <= 1'b1;
            ok      <= 1'b0;
            st      <= AP_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        AP_GAP: begin
          upd_req <= 1'b1;
          tcnt    <= '0;
          st      <= AP_REQ;
        end
        default: st <= AP_IDLE;
      endcase
    end
  end

  // R2: the value seen by the delay logic does not move under a live request
  p_req_tap_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && $past(upd_req)) |-> $stable(tap_field));

  // R3: the wait counter never passes the timeout window
  p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> (tcnt < TW'(UPD_TIMEOUT)));

  // R2: a taken request is dropped on the next cycle
  p_req_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && upd_taken && st == AP_REQ) |=> !upd_req);

endmodule

// File: rtl/tune_streak.sv
module tune_streak #(
  parameter int IDX_W = 6,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rec,
  input  logic             pass,
  input  logic [IDX_W-1:0] idx,
  output logic [LEN_W-1:0] best_len,
  output logic [IDX_W-1:0] best_end
);

  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] cur_nxt;

  always_comb cur_nxt = cur_len + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_len  <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (clear) begin
      cur_len  <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (rec) begin
      if (pass) begin
        cur_len <= cur_nxt;
        if (cur_nxt > best_len) begin
          best_len <= cur_nxt;
          best_end <= idx;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end

  // R5: the best run only grows between clears
  p_best_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (best_len >= $past(best_len)));

  // R5: the running streak never exceeds the recorded best
  p_cur_le_best_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len <= best_len);

endmodule

// File: rtl/tune_pick.sv
module tune_pick #(
  parameter int IDX_W = 6,
  parameter int LEN_W = 6
) (
  input  logic [LEN_W-1:0] best_len,
  input  logic [IDX_W-1:0] best_end,
  output logic [IDX_W-1:0] centre
);

  localparam int SW = (IDX_W > LEN_W) ? IDX_W : LEN_W;

  logic [SW-1:0] half;
  logic [SW-1:0] diff;

  always_comb begin
    half   = SW'(best_len >> 1);
    diff   = SW'(best_end) - half;
    centre = diff[IDX_W-1:0];
  end

  // R6: the centre lies inside the run whenever a run exists
  always_comb begin
    if (best_len != '0) begin
      a_centre_in_run_r6: assert (SW'(best_end) >= half);
    end
  end

endmodule

// File: rtl/tune_sweep_engine.sv
module tune_sweep_engine
  import tune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int NUM_TAPS    = 40,
  parameter int UPD_TIMEOUT = 16,
  parameter int UPD_REPEAT  = 2,
  parameter int SETTLE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [TAP_W-1:0] tap_sel,
  output logic [TAP_W-1:0] tap_field,
  output logic             upd_req,
  input  logic             upd_taken,
  output logic             chk_start,
  input  logic             chk_done,
  input  logic             chk_pass
);

  localparam int LEN_W = $clog2(NUM_TAPS + 1);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [TAP_W-1:0] IDX_LAST = TAP_W'(NUM_TAPS - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  sweep_st_e        st;
  logic [TAP_W-1:0] idx;
  logic [SET_W-1:0] scnt;
  logic             ap_go;
  logic [TAP_W-1:0] ap_tap;
  logic             ap_fin;
  logic             ap_ok;
  logic             str_clr;
  logic             rec;
  logic             rec_pass;
  logic [LEN_W-1:0] best_len;
  logic [TAP_W-1:0] best_end;
  logic [TAP_W-1:0] centre;

  tune_apply #(
    .TAP_W      (TAP_W),
    .UPD_TIMEOUT(UPD_TIMEOUT),
    .UPD_REPEAT (UPD_REPEAT)
  ) u_apply (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (ap_go),
    .tap_in   (ap_tap),
    .tap_field(tap_field),
    .upd_req  (upd_req),
    .upd_taken(upd_taken),
    .fin      (ap_fin),
    .ok       (ap_ok)
  );

  tune_streak #(
    .IDX_W(TAP_W),
    .LEN_W(LEN_W)
  ) u_streak (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (str_clr),
    .rec     (rec),
    .pass    (rec_pass),
    .idx     (idx),
    .best_len(best_len),
    .best_end(best_end)
  );

  tune_pick #(
    .IDX_W(TAP_W),
    .LEN_W(LEN_W)
  ) u_pick (
    .best_len(best_len),
    .best_end(best_end),
    .centre  (centre)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SW_IDLE;
      idx       <= '0;
      scnt      <= '0;
      ap_go     <= 1'b0;
      ap_tap    <= '0;
      str_clr   <= 1'b0;
      rec       <= 1'b0;
      rec_pass  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      tap_sel   <= '0;
      chk_start <= 1'b0;
    end else begin
      ap_go     <= 1'b0;
      str_clr   <= 1'b0;
      rec       <= 1'b0;
      done      <= 1'b0;
      chk_start <= 1'b0;
      unique case (st)
        SW_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            err     <= 1'b0;
            tap_sel <= '0;
            idx     <= '0;
            str_clr <= 1'b1;
            ap_go   <= 1'b1;
            ap_tap  <= '0;
            st      <= SW_APPLY;
          end
        end
        SW_APPLY: begin
          if (ap_fin) begin
            if (ap_ok) begin
              scnt <= '0;
              st   <= SW_SETTLE;
            end else begin
              rec      <= 1'b1;
              rec_pass <= 1'b0;
              st       <= SW_NEXT;
            end
          end
        end
        SW_SETTLE: begin
          if (scnt == SET_LAST) begin
            chk_start <= 1'b1;
            st        <= SW_WAIT;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        SW_WAIT: begin
          if (chk_done) begin
            rec      <= 1'b1;
            rec_pass <= chk_pass;
            st       <= SW_NEXT;
          end
        end
        SW_NEXT: begin
          if (idx == IDX_LAST) begin
            st <= SW_PICK;
          end else begin
            idx    <= idx + 1'b1;
            ap_tap <= idx + 1'b1;
            ap_go  <= 1'b1;
            st     <= SW_APPLY;
          end
        end
        SW_PICK: begin
          if (best_len == '0) begin
            done <= 1'b1;
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= SW_IDLE;
          end else begin
            tap_sel <= centre;
            ap_tap  <= centre;
            ap_go   <= 1'b1;
            st      <= SW_FINAL;
          end
        end
        SW_FINAL: begin
          if (ap_fin) begin
            done <= 1'b1;
            err  <= !ap_ok;
            busy <= 1'b0;
            st   <= SW_IDLE;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  // R10: done lasts exactly one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy falls together with done
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: an empty sweep always ends in error
  p_nopass_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && best_len == '0) |-> err);

  // R4: no check is launched while an update is in flight
  p_chk_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start |-> !upd_req);

  // R6: a successful result is inside the swept range
  p_sel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (tap_sel <= IDX_LAST));

  // R9: the running tap index never jumps back while busy
  p_idx_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx >= $past(idx)));

endmodule

// File: tb/tune_sweep_engine_tb.sv
module tune_sweep_engine_tb;

  localparam int TAP_W    = 6;
  localparam int NTAP     = 40;
  localparam int TMO      = 8;
  localparam int SETTLE   = 3;
  localparam int NVEC     = 9;
  localparam logic [TAP_W-1:0] NONE = 6'd63;

  typedef struct packed {
    logic [NTAP-1:0]  mask;
    logic [3:0]       dly;
    logic [TAP_W-1:0] dead;
    logic [TAP_W-1:0] exp_tap;
    logic             exp_err;
    logic [7:0]       exp_chk;
    logic [7:0]       exp_upd;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{40'hFF_FFFF_FFFF, 4'd1, NONE,  6'd19, 1'b0, 8'd40, 8'd82},
    '{40'h00_0000_0000, 4'd1, NONE,  6'd0,  1'b1, 8'd40, 8'd80},
    '{40'h00_0000_0080, 4'd0, NONE,  6'd7,  1'b0, 8'd40, 8'd82},
    '{40'h00_0000_3C3C, 4'd2, NONE,  6'd3,  1'b0, 8'd40, 8'd82},
    '{40'hFF_C000_01FF, 4'd1, NONE,  6'd34, 1'b0, 8'd40, 8'd82},
    '{40'h00_01F0_0000, 4'd1, NONE,  6'd22, 1'b0, 8'd40, 8'd82},
    '{40'hFF_FFFF_FFFF, 4'd1, 6'd15, 6'd27, 1'b0, 8'd39, 8'd81},
    '{40'hFF_FFFF_FFFF, 4'd7, NONE,  6'd19, 1'b0, 8'd40, 8'd82},
    '{40'hFF_FFFF_FFFF, 4'd8, NONE,  6'd0,  1'b1, 8'd0,  8'd40}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             busy, done, err;
  logic [TAP_W-1:0] tap_sel, tap_field;
  logic             upd_req, chk_start;
  logic             upd_taken = 1'b0;
  logic             chk_done = 1'b0;
  logic             chk_pass = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [NTAP-1:0]  cur_mask = '0;
  int               cur_dly = 1;
  logic [TAP_W-1:0] cur_dead = NONE;
  int               cnt_chk = 0;
  int               cnt_upd = 0;
  int               settle_bad = 0;
  int               order_bad = 0;

  always #2 clk = ~clk;

  tune_sweep_engine #(
    .TAP_W      (TAP_W),
    .NUM_TAPS   (NTAP),
    .UPD_TIMEOUT(TMO),
    .UPD_REPEAT (2),
    .SETTLE_CYC (SETTLE)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .tap_sel  (tap_sel),
    .tap_field(tap_field),
    .upd_req  (upd_req),
    .upd_taken(upd_taken),
    .chk_start(chk_start),
    .chk_done (chk_done),
    .chk_pass (chk_pass)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end

  // delay-line model: takes each request after cur_dly negedges, never for cur_dead
  initial begin
    int  wcnt = 0;
    logic served = 1'b0;
    logic prev_req = 1'b0;
    forever begin
      @(negedge clk);
      if (upd_req && !prev_req) cnt_upd++;
      prev_req = upd_req;
      if (!upd_req) begin
        wcnt = 0;
        served = 1'b0;
        upd_taken = 1'b0;
      end else if (served) begin
        upd_taken = 1'b0;
      end else if (tap_field != cur_dead) begin
        if (wcnt == cur_dly) begin
          upd_taken = 1'b1;
          served = 1'b1;
        end else begin
          wcnt++;
        end
      end
    end
  end

  // checker model: answers two cycles after chk_start with the mask bit of the tap
  initial begin
    int gap = 0;
    int last_tap = -1;
    int pend = 0;
    forever begin
      @(negedge clk);
      chk_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          chk_done = 1'b1;
          chk_pass = cur_mask[tap_field];
        end
      end
      if (chk_start) begin
        cnt_chk++;
        if (gap < SETTLE) settle_bad++;
        if (int'(tap_field) <= last_tap) order_bad++;
        last_tap = int'(tap_field);
        pend = 2;
      end
      if (!busy) last_tap = -1;
      if (upd_req) gap = 0;
      else gap++;
    end
  end

  task automatic run_vec(input vec_t v, input int k);
    int  waited = 0;
    logic got_err;
    logic [TAP_W-1:0] got_tap;
    cur_mask = v.mask;
    cur_dly = int'(v.dly);
    cur_dead = v.dead;
    cnt_chk = 0;
    cnt_upd = 0;
    settle_bad = 0;
    order_bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (waited == 60) start = 1'b1;   // R9 stray start mid-sweep
      if (waited == 61) start = 1'b0;
    end
    got_err = err;
    got_tap = tap_sel;
    check(done == 1'b1, $sformatf("R10 done seen vec %0d", k), done, 1);
    check(busy == 1'b0, "R10 busy low with done", busy, 0);
    check(got_err == v.exp_err, $sformatf("R7 err vec %0d", k), got_err, v.exp_err);
    check(got_tap == v.exp_tap, $sformatf("R5 R6 tap vec %0d", k), got_tap, v.exp_tap);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(tap_sel == got_tap && err == got_err, "R10 result held", tap_sel, got_tap);
    check(busy == 1'b0, "R9 stray start ignored (no restart)", busy, 0);
    check(cnt_chk == int'(v.exp_chk), $sformatf("R1 R3 R9 check count vec %0d", k),
          cnt_chk, v.exp_chk);
    check(cnt_upd == int'(v.exp_upd), $sformatf("R2 R8 update count vec %0d", k),
          cnt_upd, v.exp_upd);
    check(settle_bad == 0, "R4 settle gap", settle_bad, 0);
    check(order_bad == 0, "R1 ascending taps", order_bad, 0);
    if (!v.exp_err)
      check(tap_field == v.exp_tap, $sformatf("R8 final tap field vec %0d", k),
            tap_field, v.exp_tap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R11 reset flags", busy, 0);
    check(upd_req == 1'b0 && chk_start == 1'b0, "R11 reset handshakes", upd_req, 0);
    check(tap_sel == '0, "R11 reset tap_sel", tap_sel, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R11 idle after reset", busy, 0);

    for (int k = 0; k < NVEC; k++) begin
      run_vec(VECS[k], k);
    end

    // R3 final-update timeout: only tap 0 passes, then the delay line stops taking tap 0
    cur_mask = 40'h1;
    cur_dly = 1;
    cur_dead = NONE;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int w = 0;
      while (!done && w < 20000) begin
        @(negedge clk);
        w++;
        if (busy && tap_field == 6'd39 && !upd_req) cur_dead = 6'd0;
      end
    end
    check(err == 1'b1, "R8 final update timeout gives err", err, 1);
    check(tap_sel == 6'd0, "R8 chosen tap kept on final timeout", tap_sel, 0);

    finish_run();
  end

endmodule